// File: doc/BRIEF.md
# ISDN Basic-Rate Receive Channel Packer

This block takes the receive side of one serial ISDN basic-rate port and turns its bit stream into host-readable words. The port carries two 64 kbps bearer channels and one 16 kbps signalling channel. Every 8 kHz frame therefore delivers eight bits to each bearer channel and two bits to the signalling channel. Bits arrive on a slow data clock and a frame sync pulse aligns them. The block samples the serial lines in its own system clock domain, works out which time slot each bit belongs to, and shifts the bit into that channel's shift register.

Four frames fill a channel's word: 32 bits for each bearer channel, 8 bits for the signalling channel. A completed word is held in a shadow register and then moved into a host register. At that point the channel's ready flag is raised, so a word arrives every fourth frame, at 2 kHz. A host polls or takes the interrupt, then reads each channel with a strobe and a channel select. A word that lands on an unread one replaces it and raises a sticky overrun flag, which the host clears explicitly.

Top module: `isdn_rx_packer`

## Requirements
- R1: During and right after a synchronous reset, `ready`, `overrun`, `irq` and `rd_data` are all zero. The shift, shadow and host registers of every channel hold all ones, so a read before any word has completed returns all ones in the channel's width (0xFFFFFFFF for a bearer channel, 0x000000FF for the signalling channel).
- R2: A data clock rising edge with `fsync` high marks bit position 0 of a frame. Bits received after reset and before the first frame sync reach no channel.
- R3: Bit positions 0–7 feed bearer channel 1, positions 8–15 feed bearer channel 2, and positions 16–17 feed the signalling channel. All higher positions are ignored.
- R4: Each slot arrives most significant bit first. In a bearer word, the byte of the first of the four frames sits in bits 31:24 and the later frames fill the lower bytes in order.
- R5: In the signalling byte, the first frame's bit pair sits in bits 7:6 and the later frames fill the lower pairs in order. Bits 31:8 of `rd_data` read as zero for this channel.
- R6: A channel's ready flag is set only once four frames have completed its word. After three frames it is still clear.
- R7: A `rd_stb` pulse with `rd_sel` equal to 0 (bearer 1), 1 (bearer 2) or 2 (signalling) loads that channel's host word into `rd_data` one cycle later and clears its ready flag. `rd_sel` equal to 3 returns zero. `rd_data` holds its value while no strobe is given.
- R8: `irq` is the OR of the three ready flags, registered one cycle later.
- R9: A completed word that arrives while the channel's ready flag is still set replaces the host word and sets that channel's overrun flag.
- R10: An overrun flag stays set through reads and further words. It clears only on an `ovr_clr` pulse whose `rd_sel` names that channel, and the other channels' flags are not affected.
- R11: Serial data is taken only on a rising edge of `dclk`. Changes of `din` while `dclk` is steady have no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, much faster than the data clock |
| rst | input | 1 | Synchronous active-high reset |
| dclk | input | 1 | Serial data clock, sampled on its rising edge |
| fsync | input | 1 | Frame sync, high on the bit that is position 0 |
| din | input | 1 | Serial receive data |
| rd_stb | input | 1 | One-cycle read strobe |
| rd_sel | input | 2 | Channel select: 0 bearer 1, 1 bearer 2, 2 signalling |
| ovr_clr | input | 1 | One-cycle overrun clear for the channel named by `rd_sel` |
| rd_data | output | 32 | Registered read data, zero-extended |
| ready | output | 3 | Per-channel word-ready flags, bit index equals `rd_sel` code |
| overrun | output | 3 | Per-channel sticky overrun flags |
| irq | output | 1 | Registered OR of the ready flags |

## Verification
A rising `dclk` edge goes through two synchronizer stages and a registered slot decoder. The shadow register is loaded on the next clock, so a channel's ready flag rises five system clocks after the rising edge that carries the last bit of its word. `irq` follows one clock later, and `rd_data` and the cleared ready flag appear on the clock after a read strobe. The bench drives each data clock phase for four system clocks and idles ten more after a frame, so every check on ready, irq or overrun falls well after its result is due. Read results are sampled on the falling clock edge that follows the strobe's cycle.

// File: rtl/isdn_rx_pkg.sv
package isdn_rx_pkg;
  localparam int NUM_CH = 3;
  localparam int CH_B1  = 0;
  localparam int CH_B2  = 1;
  localparam int CH_D   = 2;
  localparam int SEL_W  = 2;
endpackage

// File: rtl/isdn_rx_sync.sv
module isdn_rx_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic dclk,
  input  logic fsync,
  input  logic din,
  output logic rise,
  output logic fsync_s,
  output logic din_s
);
  logic [2:0] pipe [STAGES];
  logic       dclk_prev;

  always_ff @(posedge clk) begin
    if (rst) pipe[0] <= '0;
    else     pipe[0] <= {dclk, fsync, din};
  end

  for (genvar i = 1; i < STAGES; i++) begin : g_stage
    always_ff @(posedge clk) begin
      if (rst) pipe[i] <= '0;
      else     pipe[i] <= pipe[i-1];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) dclk_prev <= 1'b0;
    else     dclk_prev <= pipe[STAGES-1][2];
  end

  assign rise    = pipe[STAGES-1][2] & ~dclk_prev;
  assign fsync_s = pipe[STAGES-1][1];
  assign din_s   = pipe[STAGES-1][0];
endmodule

// File: rtl/isdn_slot_decoder.sv
module isdn_slot_decoder #(
  parameter int POS_W  = 8,
  parameter int B_BITS = 8,
  parameter int D_BITS = 2
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       rise,
  input  logic       fsync_s,
  input  logic       din_s,
  output logic [2:0] bit_vld,
  output logic       bit_val
);
  import isdn_rx_pkg::*;

  localparam logic [POS_W-1:0] B2_START = POS_W'(B_BITS);
  localparam logic [POS_W-1:0] D_START  = POS_W'(2 * B_BITS);
  localparam logic [POS_W-1:0] D_END    = POS_W'(2 * B_BITS + D_BITS);

  logic [POS_W-1:0] pos;
  logic [POS_W-1:0] npos;
  logic [2:0]       vld_n;

  always_comb begin
    if (fsync_s)        npos = '0;
    else if (pos == '1) npos = pos;
    else                npos = pos + 1'b1;
    vld_n = '0;
    if (npos < B2_START)     vld_n[CH_B1] = 1'b1;
    else if (npos < D_START) vld_n[CH_B2] = 1'b1;
    else if (npos < D_END)   vld_n[CH_D]  = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pos     <= '1;
      bit_vld <= '0;
      bit_val <= 1'b1;
    end else begin
      bit_vld <= '0;
      if (rise) begin
        pos     <= npos;
        bit_vld <= vld_n;
        bit_val <= din_s;
      end
    end
  end

  AST_SLOT_ONEHOT: assert property (@(posedge clk) disable iff (rst)
    $onehot0(bit_vld)); // R3
  AST_SLOT_NEEDS_EDGE: assert property (@(posedge clk) disable iff (rst)
    !rise |=> (bit_vld == '0)); // R11
endmodule

// File: rtl/isdn_chan_packer.sv
module isdn_chan_packer #(
  parameter int SLOT_BITS = 8,
  parameter int FRAMES    = 4
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic                          bit_vld,
  input  logic                          bit_val,
  input  logic                          rd_hit,
  input  logic                          clr_hit,
  output logic [SLOT_BITS*FRAMES-1:0]   host_word,
  output logic                          ready,
  output logic                          ovr
);
  localparam int WORD_W = SLOT_BITS * FRAMES;
  localparam int CNT_W  = $clog2(WORD_W);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(WORD_W - 1);

  logic [WORD_W-1:0] shreg;
  logic [WORD_W-1:0] shadow;
  logic [CNT_W-1:0]  cnt;
  logic              load_pend;
  logic              rst_q;

  always_ff @(posedge clk) begin
    rst_q <= rst;
    if (rst) begin
      shreg     <= '1;
      shadow    <= '1;
      host_word <= '1;
      cnt       <= '0;
      load_pend <= 1'b0;
      ready     <= 1'b0;
      ovr       <= 1'b0;
    end else begin
      load_pend <= 1'b0;
      if (bit_vld) begin
        shreg <= {shreg[WORD_W-2:0], bit_val};
        if (cnt == LAST) begin
          cnt       <= '0;
          shadow    <= {shreg[WORD_W-2:0], bit_val};
          load_pend <= 1'b1;
        end else begin
          cnt <= cnt + 1'b1;
        end
      end
      if (clr_hit) ovr <= 1'b0;
      if (load_pend) begin
        host_word <= shadow;
        ready     <= 1'b1;
        if (ready && !rd_hit) ovr <= 1'b1;
      end else if (rd_hit) begin
        ready <= 1'b0;
      end
    end
  end

  AST_RESET_ONES: assert property (@(posedge clk)
    rst_q |-> (shreg == '1 && shadow == '1)); // R1
  AST_LOAD_SETS_READY: assert property (@(posedge clk) disable iff (rst)
    load_pend |=> ready); // R6
  AST_READY_NEEDS_LOAD: assert property (@(posedge clk) disable iff (rst)
    !ready ##1 ready |-> $past(load_pend)); // R6
  AST_HOST_FROM_SHADOW: assert property (@(posedge clk) disable iff (rst)
    load_pend |=> (host_word == $past(shadow))); // R9
  AST_OVR_ON_UNREAD: assert property (@(posedge clk) disable iff (rst)
    (load_pend && ready && !rd_hit) |=> ovr); // R9
  AST_OVR_STICKY: assert property (@(posedge clk) disable iff (rst)
    (ovr && !clr_hit) |=> ovr); // R10
  AST_READ_CLEARS: assert property (@(posedge clk) disable iff (rst)
    (rd_hit && !load_pend) |=> !ready); // R7
endmodule

// File: rtl/isdn_rx_packer.sv
module isdn_rx_packer #(
  parameter int B_SLOT_BITS     = 8,
  parameter int D_SLOT_BITS     = 2,
  parameter int FRAMES_PER_WORD = 4,
  parameter int POS_W           = 8,
  parameter int SYNC_STAGES     = 2
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        dclk,
  input  logic        fsync,
  input  logic        din,
  input  logic        rd_stb,
  input  logic [1:0]  rd_sel,
  input  logic        ovr_clr,
  output logic [31:0] rd_data,
  output logic [2:0]  ready,
  output logic [2:0]  overrun,
  output logic        irq
);
  import isdn_rx_pkg::*;

  localparam int RD_W = 32;

  logic            rise, fsync_s, din_s;
  logic [2:0]      bit_vld;
  logic            bit_val;
  logic [RD_W-1:0] word_ext [NUM_CH];
  logic [RD_W-1:0] sel_word;

  isdn_rx_sync #(.STAGES(SYNC_STAGES)) i_sync (
    .clk(clk), .rst(rst), .dclk(dclk), .fsync(fsync), .din(din),
    .rise(rise), .fsync_s(fsync_s), .din_s(din_s)
  );

  isdn_slot_decoder #(.POS_W(POS_W), .B_BITS(B_SLOT_BITS), .D_BITS(D_SLOT_BITS)) i_dec (
    .clk(clk), .rst(rst), .rise(rise), .fsync_s(fsync_s), .din_s(din_s),
    .bit_vld(bit_vld), .bit_val(bit_val)
  );

  for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
    localparam int SB = (g == CH_D) ? D_SLOT_BITS : B_SLOT_BITS;
    localparam int WW = SB * FRAMES_PER_WORD;
    logic [WW-1:0] word;
    logic          rd_hit, clr_hit;

    assign rd_hit  = rd_stb  && (rd_sel == SEL_W'(g));
    assign clr_hit = ovr_clr && (rd_sel == SEL_W'(g));

    isdn_chan_packer #(.SLOT_BITS(SB), .FRAMES(FRAMES_PER_WORD)) i_pack (
      .clk(clk), .rst(rst), .bit_vld(bit_vld[g]), .bit_val(bit_val),
      .rd_hit(rd_hit), .clr_hit(clr_hit),
      .host_word(word), .ready(ready[g]), .ovr(overrun[g])
    );
    assign word_ext[g] = RD_W'(word);
  end

  always_comb begin
    case (rd_sel)
      2'd0:    sel_word = word_ext[CH_B1];
      2'd1:    sel_word = word_ext[CH_B2];
      2'd2:    sel_word = word_ext[CH_D];
      default: sel_word = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_data <= '0;
      irq     <= 1'b0;
    end else begin
      irq <= |ready;
      if (rd_stb) rd_data <= sel_word;
    end
  end

  AST_IRQ_RAISE: assert property (@(posedge clk) disable iff (rst)
    (|ready) |=> irq); // R8
  AST_IRQ_DROP: assert property (@(posedge clk) disable iff (rst)
    !(|ready) |=> !irq); // R8
  AST_RD_HOLD: assert property (@(posedge clk) disable iff (rst)
    !rd_stb |=> $stable(rd_data)); // R7
endmodule

// File: tb/test_isdn_rx_packer.sv
module test_isdn_rx_packer;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        dclk = 1'b0, fsync = 1'b0, din = 1'b0;
  logic        rd_stb = 1'b0, ovr_clr = 1'b0;
  logic [1:0]  rd_sel = 2'd0;
  logic [31:0] rd_data;
  logic [2:0]  ready, overrun;
  logic        irq;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 1'b0;

  always #10 clk = ~clk;

  isdn_rx_packer i_isdn_rx_packer (
    .clk(clk), .rst(rst), .dclk(dclk), .fsync(fsync), .din(din),
    .rd_stb(rd_stb), .rd_sel(rd_sel), .ovr_clr(ovr_clr),
    .rd_data(rd_data), .ready(ready), .overrun(overrun), .irq(irq)
  );

  // Each entry: {bearer1 byte, bearer2 byte, signalling pair, junk for positions 18-23}
  localparam logic [23:0] VEC [0:11] = '{
    {8'hA5, 8'h3C, 2'b10, 6'b111111},
    {8'h01, 8'hFE, 2'b01, 6'b000000},
    {8'h7E, 8'h81, 2'b11, 6'b101010},
    {8'hC3, 8'h5A, 2'b00, 6'b010101},
    {8'h00, 8'hFF, 2'b00, 6'b110011},
    {8'hFF, 8'h00, 2'b11, 6'b001100},
    {8'h12, 8'h34, 2'b01, 6'b111000},
    {8'h56, 8'h78, 2'b10, 6'b000111},
    {8'h80, 8'h01, 2'b10, 6'b100001},
    {8'h40, 8'h02, 2'b01, 6'b011110},
    {8'h20, 8'h04, 2'b10, 6'b110110},
    {8'h10, 8'h08, 2'b01, 6'b001001}
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wait_clk(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  // din is driven inverted first while dclk is low, then corrected (R11)
  task automatic send_bit(input logic b, input logic sync);
    @(negedge clk);
    dclk = 1'b0; din = ~b; fsync = ~sync;
    wait_clk(2);
    din = b; fsync = sync;
    wait_clk(2);
    dclk = 1'b1;
    wait_clk(2);
    din = ~b;
    wait_clk(2);
    dclk = 1'b0;
  endtask

  task automatic send_frame(input logic [23:0] v);
    for (int i = 0; i < 24; i++) send_bit(v[23-i], i == 0);
    wait_clk(10);
  endtask

  task automatic do_read(input logic [1:0] sel);
    @(negedge clk);
    rd_stb = 1'b1; rd_sel = sel;
    @(negedge clk);
    rd_stb = 1'b0;
  endtask

  task automatic do_clear(input logic [1:0] sel);
    @(negedge clk);
    ovr_clr = 1'b1; rd_sel = sel;
    @(negedge clk);
    ovr_clr = 1'b0;
  endtask

  function automatic logic [31:0] b_word(input int base, input bit second);
    logic [31:0] w;
    for (int f = 0; f < 4; f++)
      w[31-8*f -: 8] = second ? VEC[base+f][15:8] : VEC[base+f][23:16];
    return w;
  endfunction

  function automatic logic [31:0] d_word(input int base);
    logic [31:0] w = '0;
    for (int f = 0; f < 4; f++) w[7-2*f -: 2] = VEC[base+f][7:6];
    return w;
  endfunction

  initial begin
    wait_clk(5);
    check("R1 ready", {29'd0, ready}, 32'd0);
    check("R1 overrun", {29'd0, overrun}, 32'd0);
    check("R1 irq", {31'd0, irq}, 32'd0);
    check("R1 rd_data", rd_data, 32'd0);
    @(negedge clk) rst = 1'b0;
    do_read(2'd0); check("R1 bearer1 all ones", rd_data, 32'hFFFFFFFF);
    do_read(2'd2); check("R1 signalling all ones", rd_data, 32'h000000FF);

    // R2: bits before any frame sync must not reach a channel
    for (int i = 0; i < 40; i++) send_bit(i[0], 1'b0);
    wait_clk(10);
    check("R2 no ready before sync", {29'd0, ready}, 32'd0);

    for (int k = 0; k < 12; k++) begin
      send_frame(VEC[k]);
      if (k % 4 == 2) check("R6 not ready after three frames", {29'd0, ready}, 32'd0);
      if (k % 4 == 3) begin
        check("R6 ready after four frames", {29'd0, ready}, 32'd7);
        check("R8 irq with ready", {31'd0, irq}, 32'd1);
        do_read(2'd0); check("R4 R3 R11 bearer1 word", rd_data, b_word(k-3, 1'b0));
        do_read(2'd1); check("R4 R3 bearer2 word", rd_data, b_word(k-3, 1'b1));
        do_read(2'd2); check("R5 R3 signalling byte", rd_data, d_word(k-3));
        wait_clk(2);
        check("R7 ready cleared by reads", {29'd0, ready}, 32'd0);
        check("R8 irq drops", {31'd0, irq}, 32'd0);
        check("R9 no overrun when read", {29'd0, overrun}, 32'd0);
      end
    end

    do_read(2'd3); check("R7 select 3 reads zero", rd_data, 32'd0);
    wait_clk(3);
    check("R7 rd_data holds", rd_data, 32'd0);

    // Overrun: two words per channel without reading
    for (int k = 0; k < 8; k++) send_frame(VEC[k]);
    check("R9 overrun on all channels", {29'd0, overrun}, 32'd7);
    do_read(2'd0); check("R9 newer bearer1 word kept", rd_data, b_word(4, 1'b0));
    do_read(2'd2); check("R9 newer signalling byte kept", rd_data, d_word(4));
    wait_clk(2);
    check("R10 overrun survives reads", {29'd0, overrun}, 32'd7);
    do_clear(2'd0); wait_clk(1);
    check("R10 clear only bearer1", {29'd0, overrun}, 32'd6);
    for (int k = 8; k < 12; k++) send_frame(VEC[k]);
    check("R10 bearer2 stays after new word", {29'd0, overrun}, 32'd6);
    check("R9 ready again", {29'd0, ready}, 32'd7);
    do_clear(2'd1); do_clear(2'd2); wait_clk(1);
    check("R10 all cleared", {29'd0, overrun}, 32'd0);

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    for (int i = 0; i < 190000; i++) @(posedge clk);
    if (!done) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule